// File: doc/BRIEF.md
# Atomic Split-Read Counter Capture

This block lets a 32-bit data path read a free-running 64-bit system counter as a single coherent value using two ordinary reads. A lone read returns the low half of the counter and, in the same step, keeps the interrupt controller from taking an interrupt for a short holdoff window. If a second read lands inside that window, it returns the upper half. That upper half comes from a short fixed-depth pipeline of the counter's upper bits, not from the live counter. The two halves therefore describe the counter at one instant, even when the low half wrapped between the two reads.

The block has no upper holding register. A delay line of the upper bits, as deep as the holdoff, supplies the upper half, and the holdoff keeps an interrupt from splitting the pair. The system has only one counter, so only one instance is needed. Its outputs go to every reader and to the interrupt controller, which is outside this block.

Top module: `ctsplit_atomic_reader`

## Requirements
- R1: After reset, `rd_data` is 0 and `irq_inhibit` is low.
- R2: A read strobe that is not a second read is a first read. The cycle after its sampling edge, `rd_data` shows bits [31:0] of `cnt_in` as sampled at that edge.
- R3: A first read drives `irq_inhibit` high from the cycle after its edge, for exactly HOLD (default 2) consecutive cycles, unless another first read restarts the count.
- R4: A strobe at one of the HOLD edges following a first read is a second read, provided no second read has yet answered that first read. The cycle after its edge, `rd_data` shows bits [63:32] of `cnt_in` as sampled at the first read's edge, so a carry out of the low half after that edge is not seen.
- R5: A second read neither restarts nor lengthens `irq_inhibit`. The inhibit ends at the same cycle it would have ended without the second read.
- R6: A strobe after the holdoff window has closed, or after a pair has completed, is treated as a new first read with the R2 and R3 behaviour.
- R7: In a cycle with no strobe, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_strobe | input | 1 | Counter read request, one per cycle |
| cnt_in | input | 64 | Live system counter value |
| rd_data | output | 32 | Registered read result, low or high half |
| irq_inhibit | output | 1 | Holds off interrupt entry while high |

## Verification
The hardest case is a second read whose upper half must differ from the live counter. This needs the low half to wrap between the first read and the second read. A free-running counter reaches that point only every few billion cycles. The stimulus therefore loads the counter with a value a few counts below a low-half wrap and then issues read pairs at both legal spacings. Random pair, late-read and idle patterns are mixed in, with occasional reloads near a wrap, so that carries fall both inside and outside holdoff windows.

// File: rtl/ctsplit_pkg.sv
package ctsplit_pkg;

   // Tracks where the reader stands relative to a read pair.
   typedef enum logic [1:0] {
      PAIR_IDLE   = 2'd0,  // nothing read since reset
      PAIR_OPEN   = 2'd1,  // first read taken, second may follow
      PAIR_CLOSED = 2'd2   // pair answered or window lapsed
   } pair_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/ctsplit_hi_delay.sv
module ctsplit_hi_delay #(
   parameter int unsigned HI_W  = 32,
   parameter int unsigned DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [HI_W-1:0]            hi_in,
   output logic [DEPTH-1:0][HI_W-1:0] taps
);

   // Stage k holds the upper bits sampled k+1 edges ago.
   logic [DEPTH-1:0][HI_W-1:0] stage_q;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_stage
         if (k == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[k] <= '0;
               else        stage_q[k] <= hi_in;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[k] <= '0;
               else        stage_q[k] <= stage_q[k-1];
            end
         end
      end
   endgenerate

   assign taps = stage_q;

   // The first stage always reflects the previous edge's input.
   a_r4_head_tracks_input: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> stage_q[0] == $past(hi_in));

endmodule

// File: rtl/ctsplit_holdoff.sv
module ctsplit_holdoff #(
   parameter int unsigned HOLD = 2,
   localparam int unsigned CW  = ctsplit_pkg::cnt_width(HOLD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          inhibit,
   output logic [CW-1:0] remain
);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_q <= '0;
      else if (start)            remain_q <= CW'(HOLD);
      else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
   end

   assign remain  = remain_q;
   assign inhibit = (remain_q != '0);

   // Checker counter: length of the current inhibit run.
   logic [CW:0] run_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_len_q <= '0;
      else if (start)    run_len_q <= '0;
      else if (inhibit)  run_len_q <= run_len_q + 1'b1;
      else               run_len_q <= '0;
   end

   a_r3_start_raises: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> inhibit);

   a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> run_len_q < (CW+1)'(HOLD));

   a_r3_no_spontaneous_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!inhibit && !start) |=> !inhibit);

endmodule

// File: rtl/ctsplit_pair_fsm.sv
module ctsplit_pair_fsm #(
   parameter int unsigned HOLD = 2,
   localparam int unsigned CW  = ctsplit_pkg::cnt_width(HOLD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic [CW-1:0] remain,
   output logic          is_first,
   output logic          is_second,
   output logic [CW-1:0] tap_sel
);

   import ctsplit_pkg::*;

   pair_state_e state_q, state_d;
   logic        window_open;

   assign window_open = (state_q == PAIR_OPEN) && (remain != '0);
   assign is_second   = strobe && window_open;
   assign is_first    = strobe && !window_open;
   // Edges elapsed since the first read, minus one, picks the delay tap.
   assign tap_sel     = CW'(HOLD) - remain;

   always_comb begin
      state_d = state_q;
      if (is_first)
         state_d = PAIR_OPEN;
      else if (is_second)
         state_d = PAIR_CLOSED;
      else if (state_q == PAIR_OPEN && remain == '0)
         state_d = PAIR_CLOSED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PAIR_IDLE;
      else        state_q <= state_d;
   end

   a_r6_one_answer_per_pair: assert property (@(posedge clk) disable iff (!rst_n)
      is_second |=> !is_second);

   a_r6_first_opens: assert property (@(posedge clk) disable iff (!rst_n)
      is_first |=> state_q == PAIR_OPEN);

   a_r4_second_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      is_second |-> (tap_sel < CW'(HOLD)));

endmodule

// File: rtl/ctsplit_atomic_reader.sv
module ctsplit_atomic_reader #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HOLD   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic [CNT_W-1:0]  cnt_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_inhibit
);

   localparam int unsigned HI_W = CNT_W - DATA_W;
   localparam int unsigned CW   = ctsplit_pkg::cnt_width(HOLD);

   // Elaboration-time parameter checks.
   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("HOLD must be at least 1");
      end
      if (CNT_W <= DATA_W || HI_W > DATA_W) begin : g_bad_width
         $error("CNT_W must exceed DATA_W and be at most twice DATA_W");
      end
   endgenerate

   logic [HOLD-1:0][HI_W-1:0] hi_taps;
   logic [CW-1:0]             remain;
   logic                      is_first, is_second;
   logic [CW-1:0]             tap_sel;
   logic [HI_W-1:0]           hi_sel;
   logic [DATA_W-1:0]         hi_word;
   logic [DATA_W-1:0]         rd_q;

   ctsplit_hi_delay #(.HI_W(HI_W), .DEPTH(HOLD)) i_hi_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_in (cnt_in[CNT_W-1:DATA_W]),
      .taps  (hi_taps)
   );

   ctsplit_holdoff #(.HOLD(HOLD)) i_holdoff (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (is_first),
      .inhibit (irq_inhibit),
      .remain  (remain)
   );

   ctsplit_pair_fsm #(.HOLD(HOLD)) i_pair_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (rd_strobe),
      .remain    (remain),
      .is_first  (is_first),
      .is_second (is_second),
      .tap_sel   (tap_sel)
   );

   always_comb begin
      hi_sel = '0;
      for (int i = 0; i < HOLD; i++) begin
         if (tap_sel == CW'(i)) hi_sel = hi_taps[i];
      end
   end

   generate
      if (HI_W == DATA_W) begin : g_hi_full
         assign hi_word = hi_sel;
      end else begin : g_hi_pad
         assign hi_word = {{(DATA_W-HI_W){1'b0}}, hi_sel};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_q <= '0;
      else if (is_first)  rd_q <= cnt_in[DATA_W-1:0];
      else if (is_second) rd_q <= hi_word;
   end

   assign rd_data = rd_q;

   a_r2_low_capture: assert property (@(posedge clk) disable iff (!rst_n)
      is_first |=> rd_data == $past(cnt_in[DATA_W-1:0]));

   a_r4_upper_early_tap: assert property (@(posedge clk) disable iff (!rst_n)
      (is_second && remain == CW'(HOLD)) |=>
         rd_data[HI_W-1:0] == $past(cnt_in[CNT_W-1:DATA_W], 2));

   a_r5_second_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
      is_second |=> remain == CW'($past(remain) - 1'b1));

   a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_data));

endmodule

// File: tb/test_ctsplit_atomic_reader.sv
module test_ctsplit_atomic_reader;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 2;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [63:0] cnt_in = '0;
   logic [31:0] rd_data;
   logic        irq_inhibit;

   ctsplit_atomic_reader i_ctsplit_atomic_reader (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_strobe   (rd_strobe),
      .cnt_in      (cnt_in),
      .rd_data     (rd_data),
      .irq_inhibit (irq_inhibit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   // Bench model state, derived from the requirements.
   logic [63:0] cnt_q = 64'h0;
   logic [31:0] m_data = '0;
   int          m_hold = 0;
   bit          m_open = 0;
   bit          m_seen = 0;
   logic [31:0] m_hist [HOLD];

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_upper(input int tap);
      return m_hist[tap];
   endfunction

   // One clock: drive at negedge, model the edge, check after it.
   task automatic step(input bit s);
      string dreq, ireq;
      bit    inwin;
      @(negedge clk);
      rd_strobe = s;
      cnt_in    = cnt_q;
      @(posedge clk);
      #1;
      inwin = m_open && (m_hold != 0);
      if (s && inwin) begin
         m_data = exp_upper(HOLD - m_hold);
         m_open = 0;
         m_hold--;
         dreq = "R4"; ireq = "R5";
      end else if (s) begin
         m_data = cnt_q[31:0];
         m_hold = HOLD;
         dreq = m_seen ? "R6" : "R2"; ireq = "R3";
         m_open = 1;
         m_seen = 1;
      end else begin
         if (m_hold > 0) m_hold--;
         dreq = "R7"; ireq = "R3";
      end
      for (int k = HOLD-1; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = cnt_q[63:32];
      check(dreq, "rd_data", rd_data, m_data);
      check(ireq, "irq_inhibit", {31'b0, irq_inhibit}, {31'b0, m_hold != 0});
      cnt_q = cnt_q + 64'd1;
   endtask

   initial begin
      void'($urandom(32'd1357));
      for (int k = 0; k < HOLD; k++) m_hist[k] = '0;
      #(3*CLK_PERIOD);
      // R1: reset state
      check("R1", "rd_data", rd_data, 32'h0);
      check("R1", "irq_inhibit", {31'b0, irq_inhibit}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      cnt_q = 64'h0000_0003_0000_0010;
      step(0);
      // Pair at spacing 1 (R2, R4, R5)
      step(1); step(1); step(0); step(0);
      // Pair at spacing 2
      step(1); step(0); step(1); step(0); step(0);
      // Late read after window (R6)
      step(1); step(0); step(0); step(1); step(0); step(0); step(0);
      // Three reads in a row: third is a new first read (R6)
      step(1); step(1); step(1); step(0); step(0); step(0);
      // Carry across the pair, spacing 2 (R4 coherence)
      cnt_q = 64'h0000_0005_FFFF_FFFF;
      step(1); step(0); step(1); step(0); step(0);
      // Carry across the pair, spacing 1
      cnt_q = 64'h0000_0009_FFFF_FFFF;
      step(1); step(1); step(0); step(0);
      // Random mix with reloads near a low-half wrap
      for (int n = 0; n < 4000; n++) begin
         if (($urandom % 64) == 0)
            cnt_q = {$urandom, 32'hFFFF_FFFF - ($urandom % 4)};
         step(($urandom % 5) < 2);
      end
      step(0); step(0); step(0);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule